// File: doc/BRIEF.md
# Row Zero-Suppression Cluster Encoder

This block compresses one row of binary pixel hits at a time. The rows arrive in rolling-shutter order as a parallel vector with a valid strobe. The block scans the captured row from the lowest column upward. For each group of adjacent hit columns it emits one compact word: the column of the group's first pixel and a small run-length code. Columns with no hit produce no traffic at all, so a sparse row shrinks to a few words.

The output is a valid/ready stream with three word kinds. A row-start marker opens a row that has hits. Cluster words follow, and a row-end marker closes every row. Both markers carry the row number. That number is counted internally, one step per accepted row, and wraps after the last row of the frame. One row is held in the block at a time. The next row can be captured in the same cycle that the current row's end marker is taken. Back-pressure from the consumer stalls the scan without losing or repeating any word.

Top module: `rzs_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `row_ready` is 1, and the row counter restarts at 0.
- R2: A row is captured when `row_valid` and `row_ready` are both 1. If it has at least one hit, the first word emitted for it is a row-start marker: `out_kind` = 2'b01, `out_addr` = row number, `out_code` = 0.
- R3: Each group of adjacent hits emits one cluster word: `out_kind` = 2'b00, `out_addr` = the lowest column of the group, and `out_code` = group length minus one (00 means one pixel, 11 means four). Bit i of `row_hits` is column i.
- R4: A run of more than MAXRUN adjacent hits is split into consecutive groups of MAXRUN pixels. Each new group starts at the next column that has not been encoded, and the last group holds the remainder.
- R5: Cluster words within a row leave in strictly ascending column order.
- R6: Columns without a hit produce no word. A row with no hits produces only its row-end marker, with no start marker.
- R7: Every captured row ends with exactly one row-end marker: `out_kind` = 2'b10, `out_addr` = row number, `out_code` = 0. Row numbers start at 0, advance by one per row, and wrap to 0 after NROW-1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the presented word is held unchanged. No word is lost or duplicated under back-pressure.
- R9: `row_ready` is 0 while a row is being emitted, and `row_valid` has no effect then. The one exception is the cycle in which the row-end marker is accepted: `row_ready` is 1 in that cycle, so the next row is captured with no idle cycle.
- R10: A group that reaches column NCOL-1 is cut at the row edge. It never extends past the last column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | A row vector is offered |
| row_hits | input | NCOL | Hit flags, bit i = column i |
| row_ready | output | 1 | The block can capture a row this cycle |
| out_valid | output | 1 | An output word is presented |
| out_ready | input | 1 | The consumer takes the word this cycle |
| out_kind | output | 2 | 00 cluster, 01 row start, 10 row end |
| out_addr | output | max(log2 NCOL, log2 NROW) | First column of a cluster, or the row number in a marker |
| out_code | output | log2 MAXRUN | Cluster length minus one; 0 in markers |

## Verification
Two events can fall in the same cycle: the handshake of one row's end marker and the capture of the next row. The bench provokes this by offering rows back to back, with the consumer either always ready or stalled at random. Each time an end marker is taken, the bench checks that `row_ready` is high. It then checks that the following row's words continue the expected stream with the advanced row number, so a lost, doubled or early-captured row shows up as a word mismatch or a wrong cluster count.

// File: rtl/rzs_pkg.sv
package rzs_pkg;

    typedef enum logic [1:0] {
        WK_CLUSTER   = 2'b00,
        WK_ROW_START = 2'b01,
        WK_ROW_END   = 2'b10
    } word_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_HEAD = 2'b01,
        ST_BODY = 2'b10
    } scan_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rzs_lead_finder.sv
// Returns the index of the lowest set bit of the pending row.
module rzs_lead_finder #(
    parameter int NCOL  = 32,
    parameter int COL_W = $clog2(NCOL)
) (
    input  logic [NCOL-1:0]  bits,
    output logic             found,
    output logic [COL_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCOL - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = COL_W'(i);
            end
        end
    end
endmodule

// File: rtl/rzs_run_measure.sv
// Measures the run of adjacent set bits starting at 'start', capped at MAXRUN,
// and produces the mask of the columns that the run consumes.
module rzs_run_measure #(
    parameter int NCOL   = 32,
    parameter int MAXRUN = 4,
    parameter int COL_W  = $clog2(NCOL),
    parameter int CODE_W = $clog2(MAXRUN)
) (
    input  logic [NCOL-1:0]   bits,
    input  logic [COL_W-1:0]  start,
    output logic [CODE_W-1:0] code,
    output logic [NCOL-1:0]   clear_mask
);
    logic [NCOL-1:0]   aligned;
    logic [MAXRUN-1:0] chain;
    logic [CODE_W:0]   run_len;

    // Bits above the row edge shift in as zero, which cuts runs at the last column.
    assign aligned = bits >> start;

    genvar k;
    generate
        for (k = 0; k < MAXRUN; k++) begin : g_chain
            if (k == 0) begin : g_first
                assign chain[k] = aligned[0];
            end else begin : g_next
                assign chain[k] = chain[k-1] & aligned[k];
            end
        end
    endgenerate

    assign run_len    = (CODE_W+1)'($countones(chain));
    assign code       = CODE_W'(run_len - 1'b1);
    assign clear_mask = NCOL'(chain) << start;
endmodule

// File: rtl/rzs_top.sv
module rzs_top
    import rzs_pkg::*;
#(
    parameter int NCOL   = 32,
    parameter int NROW   = 64,
    parameter int MAXRUN = 4,
    localparam int COL_W  = $clog2(NCOL),
    localparam int ROW_W  = $clog2(NROW),
    localparam int AW     = int'(max_u(COL_W, ROW_W)),
    localparam int CODE_W = $clog2(MAXRUN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_valid,
    input  logic [NCOL-1:0]   row_hits,
    output logic              row_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [AW-1:0]     out_addr,
    output logic [CODE_W-1:0] out_code
);
    scan_state_e       state_q;
    logic [NCOL-1:0]   pend_q;
    logic [ROW_W-1:0]  row_q;

    logic              found;
    logic [COL_W-1:0]  lead_idx;
    logic [CODE_W-1:0] run_code;
    logic [NCOL-1:0]   run_mask;
    logic              end_now;
    logic              take_row;
    word_kind_e        kind;

    rzs_lead_finder #(.NCOL(NCOL), .COL_W(COL_W)) finder_i (
        .bits  (pend_q),
        .found (found),
        .idx   (lead_idx)
    );

    rzs_run_measure #(.NCOL(NCOL), .MAXRUN(MAXRUN), .COL_W(COL_W), .CODE_W(CODE_W)) measure_i (
        .bits       (pend_q),
        .start      (lead_idx),
        .code       (run_code),
        .clear_mask (run_mask)
    );

    assign out_valid = (state_q != ST_IDLE);
    assign end_now   = (state_q == ST_BODY) && !found;
    assign row_ready = (state_q == ST_IDLE) || (end_now && out_ready);
    assign take_row  = row_valid && row_ready;

    always_comb begin
        kind     = WK_ROW_END;
        out_addr = AW'(row_q);
        out_code = '0;
        if (state_q == ST_HEAD) begin
            kind = WK_ROW_START;
        end else if (state_q == ST_BODY && found) begin
            kind     = WK_CLUSTER;
            out_addr = AW'(lead_idx);
            out_code = run_code;
        end
    end
    assign out_kind = kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            row_q   <= '0;
        end else begin
            case (state_q)
                ST_HEAD: begin
                    if (out_ready) state_q <= ST_BODY;
                end
                ST_BODY: begin
                    if (out_ready) begin
                        if (found) begin
                            pend_q <= pend_q & ~run_mask;
                        end else begin
                            state_q <= ST_IDLE;
                            row_q   <= (row_q == ROW_W'(NROW - 1)) ? '0 : row_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if (take_row) begin
                pend_q  <= row_hits;
                state_q <= (|row_hits) ? ST_HEAD : ST_BODY;
            end
        end
    end
endmodule

// File: rtl/rzs_top_chk.sv
module rzs_top_chk #(
    parameter int NCOL   = 32,
    parameter int AW     = 5,
    parameter int CODE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              row_valid,
    input logic              row_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_kind,
    input logic [AW-1:0]     out_addr,
    input logic [CODE_W-1:0] out_code
);
    logic in_row_q;
    logic seen_q;
    int   last_end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_row_q   <= 1'b0;
            seen_q     <= 1'b0;
            last_end_q <= 0;
        end else if (out_valid && out_ready) begin
            if (out_kind == 2'b01) begin
                in_row_q <= 1'b1;
                seen_q   <= 1'b0;
            end else if (out_kind == 2'b10) begin
                in_row_q <= 1'b0;
                seen_q   <= 1'b0;
            end else begin
                seen_q     <= 1'b1;
                last_end_q <= int'(out_addr) + int'(out_code);
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !out_valid && row_ready);

    p_accept_shows_word_r2: assert property (@(posedge clk) disable iff (rst)
        row_valid && row_ready |=> out_valid);

    p_cluster_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == 2'b00 |-> in_row_q);

    p_ascending_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == 2'b00 && seen_q |-> int'(out_addr) > last_end_q);

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_addr) && $stable(out_code));

    p_busy_blocks_row_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !(out_kind == 2'b10 && out_ready) |-> !row_ready);

    p_group_in_row_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == 2'b00 |-> int'(out_addr) + int'(out_code) < NCOL);
endmodule

bind rzs_top rzs_top_chk #(.NCOL(NCOL), .AW(AW), .CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .row_valid (row_valid),
    .row_ready (row_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_addr  (out_addr),
    .out_code  (out_code)
);

// File: tb/rzs_top_tb_top.sv
`timescale 1ns/1ps
module rzs_top_tb_top;
    localparam int NCOL = 16;
    localparam int NROW = 8;
    localparam int MAXRUN = 4;
    localparam int NVEC = 12;

    // Stimulus rows and hand-counted cluster words per row.
    localparam logic [15:0] VEC_HITS [NVEC] = '{
        16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h001F, 16'h5555,
        16'h00F0, 16'hE007, 16'h0F0F, 16'h3E7C, 16'h1248, 16'hFFFE };
    localparam int VEC_NCL [NVEC] = '{ 0, 1, 1, 4, 2, 8, 1, 2, 2, 4, 4, 4 };

    logic        clk = 1'b0;
    logic        rst;
    logic        row_valid;
    logic [15:0] row_hits;
    logic        row_ready;
    logic        out_valid;
    logic        out_ready;
    logic [1:0]  out_kind;
    logic [3:0]  out_addr;
    logic [1:0]  out_code;

    int checks = 0;
    int errors = 0;
    int tb_row = 0;
    int ncl = 0;
    int mode = 0;
    logic [7:0] lfsr = 8'hA5;
    bit   finished = 0;
    int   exp_q[$];
    int   cnt_q[$];
    bit   prev_stall = 0;
    int   prev_word = 0;

    always #4 clk = ~clk;

    rzs_top #(.NCOL(NCOL), .NROW(NROW), .MAXRUN(MAXRUN)) dut_i (
        .clk(clk), .rst(rst), .row_valid(row_valid), .row_hits(row_hits),
        .row_ready(row_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_addr(out_addr), .out_code(out_code));

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int pack(input int kind, input int addr, input int code);
        return kind * 256 + addr * 4 + code;
    endfunction

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mode == 0) out_ready = 1'b1;
        else if (mode == 1) out_ready = lfsr[0] | lfsr[3];
        else out_ready = 1'b0;
    end

    always @(negedge clk) begin
        int w;
        w = pack(out_kind, out_addr, out_code);
        if (rst) begin
            prev_stall = 0;
        end else begin
            if (prev_stall) chk(out_valid && w == prev_word, "R8 held word", w, prev_word);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected word", w, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e / 256 == 1) chk(w == e, "R2 start marker", w, e);
                    else if (e / 256 == 0) chk(w == e, "R3 cluster word", w, e);
                    else chk(w == e, "R7 end marker", w, e);
                end
                if (out_kind == 2'b00) ncl++;
                if (out_kind == 2'b01) ncl = 0;
                if (out_kind == 2'b10) begin
                    chk(row_ready == 1'b1, "R9 ready at end handshake", row_ready, 1);
                    if (cnt_q.size() > 0) begin
                        int c;
                        c = cnt_q.pop_front();
                        if (c >= 0) chk(ncl == c, "R4 clusters per row", ncl, c);
                    end
                    ncl = 0;
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_word  = w;
        end
    end

    // Reference stream built from the requirements.
    task automatic model_row(input logic [15:0] h);
        int c;
        if (h != 0) exp_q.push_back(pack(1, tb_row, 0));
        c = 0;
        while (c < NCOL) begin
            if (h[c]) begin
                int len;
                len = 1;
                while (len < MAXRUN && c + len < NCOL && h[c+len]) len++;
                exp_q.push_back(pack(0, c, len - 1));
                c = c + len;
            end else begin
                c++;
            end
        end
        exp_q.push_back(pack(2, tb_row, 0));
        tb_row = (tb_row == NROW - 1) ? 0 : tb_row + 1;
    endtask

    task automatic send_row(input logic [15:0] h, input int ncount);
        @(negedge clk);
        while (!row_ready) @(negedge clk);
        model_row(h);
        cnt_q.push_back(ncount);
        row_valid = 1'b1;
        row_hits  = h;
        @(posedge clk);
        #1;
        row_valid = 1'b0;
    endtask

    task automatic drain;
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R7 stream drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; row_valid = 1'b0; row_hits = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R1 reset valid", out_valid, 0);
        chk(row_ready, "R1 reset ready", row_ready, 1);
        @(posedge clk); #1 rst = 1'b0;

        // Table pass, consumer always ready: back-to-back rows (R9), wrap (R7).
        for (int i = 0; i < NVEC; i++) send_row(VEC_HITS[i], VEC_NCL[i]);

        // R9: a row offered while busy is ignored.
        send_row(16'h00FF, 2);
        @(negedge clk);
        row_valid = 1'b1; row_hits = 16'hAAAA;
        chk(!row_ready, "R9 busy in head", row_ready, 0);
        @(negedge clk);
        chk(!row_ready, "R9 busy in body", row_ready, 0);
        row_valid = 1'b0;
        drain();

        // Table pass under random back-pressure (R8, R5, R10).
        mode = 1;
        for (int i = 0; i < NVEC; i++) send_row(VEC_HITS[i], VEC_NCL[i]);
        drain();

        // R1: reset in the middle of a row.
        mode = 2;
        send_row(16'hFFFF, -1);
        repeat (2) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        exp_q.delete(); cnt_q.delete(); tb_row = 0; ncl = 0;
        @(negedge clk);
        chk(!out_valid, "R1 mid-row reset valid", out_valid, 0);
        chk(row_ready, "R1 mid-row reset ready", row_ready, 1);

        // R6: empty row shows only the end marker, row number restarted at 0.
        send_row(16'h0000, 0);
        @(negedge clk);
        chk(out_valid && out_kind == 2'b10 && out_addr == 4'd0, "R6 empty row end only",
            pack(out_kind, out_addr, out_code), pack(2, 0, 0));
        mode = 0;
        drain();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule